// File: doc/BRIEF.md
# Track Power and Discharge-Unit Supervisor

This block supervises the track supply and the capacitor discharge unit that drives point motors. The host sends single-cycle command strobes to switch power on or off and to throw a point. The block watches a short-circuit sense line, a "capacitor charged" level from the discharge unit and a "motion finished" strobe from the point driver. From these it drives the track enable, the discharge-unit enable and a one-cycle fire pulse. It also raises one-cycle report strobes that the host link turns into messages.

A short on a live track cuts track power at once and reports a fault. The discharge unit stays armed for a fixed grace window (nominally 500 ms) so that a point throw already in flight is not lost. A power-off request inside that window is ignored. A fault never re-arms power by itself: when the short goes away the block reports recovery and waits, switched off, for a fresh power-on. A millisecond prescaler and a millisecond counter form the grace window. Both are sized by parameters.

Top module: `trkpwr_sup`

## Requirements
- R1: While reset is asserted (asynchronously, active low) and in the first cycle after it, every output is 0.
- R2: In the off state, a power-on strobe sets both trk_en and cdu_en in the next cycle. A short seen while off does nothing.
- R3: With power on and no short, a power-off strobe clears trk_en and cdu_en in the next cycle and raises no report.
- R4: With power on, short_det high makes rpt_fault pulse for exactly one cycle. In that same next cycle trk_en falls and cdu_en stays 1.
- R5: While the short persists, cdu_en stays 1 for exactly GRACE_MS*CYC_PER_MS cycles, counted from the cycle in which trk_en fell, and then drops to 0.
- R6: A power-off strobe during the grace window has no effect: cdu_en stays 1 and no report is raised.
- R7: After the grace window, with the short still present, a power-off strobe moves to the off state without a recovery report. A later clearing of the short raises no report either.
- R8: When the short clears during the grace window or after it, rpt_fixed pulses once, and trk_en and cdu_en are 0. A power-on during a fault is ignored, and power returns only with a new power-on after recovery.
- R9: Once cdu_en is 1, the unit is charging. The first cycle in which cdu_ready is seen high gives one rpt_charged pulse in the next cycle, and the unit is then ready. Holding cdu_ready high does not repeat the pulse.
- R10: A point strobe while the unit is ready produces one fire pulse, exactly one cycle long, in the next cycle. The unit then waits for motion to end.
- R11: point_done while waiting for motion gives one rpt_pointed pulse. The unit recharges, and rpt_charged pulses again when cdu_ready is next seen high.
- R12: A point strobe in any other condition (disabled, charging, moving) gives one rpt_err pulse in the next cycle and no fire pulse.
- R13: rpt_fault only follows a cycle with trk_en high, so a short on a dead track is never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_on | input | 1 | Power-on command strobe |
| cmd_off | input | 1 | Power-off command strobe |
| cmd_point | input | 1 | Point-throw command strobe |
| short_det | input | 1 | Track short present (synchronous level) |
| cdu_ready | input | 1 | Discharge capacitor charged (level) |
| point_done | input | 1 | Point motion finished strobe |
| trk_en | output | 1 | Track power enable |
| cdu_en | output | 1 | Discharge-unit enable |
| fire | output | 1 | One-cycle point fire pulse |
| rpt_fault | output | 1 | Fault report strobe |
| rpt_fixed | output | 1 | Fault-cleared report strobe |
| rpt_charged | output | 1 | Capacitor-charged report strobe |
| rpt_pointed | output | 1 | Point-moved report strobe |
| rpt_err | output | 1 | Rejected point command strobe |

## Verification
The bench measures how long the discharge unit stays enabled during a persistent short. A prescaler or window counter that is off by one would show 19 or 21 cycles instead of 20, and a design that drops the unit together with track power would show 0. It sends power-off and power-on inside the window. A design that obeys them would switch the unit off early or bring the track back live. It also recovers a fault both inside and after the window, and forces power off during the hold phase, where a wrong design would report recovery twice or never. Point strobes are sent while charging, while moving and while disabled. A design that skips the ready check would pulse fire in those states and skip the error strobe.

// File: rtl/trkpwr_pkg.sv
package trkpwr_pkg;

  // Track power supervisor states
  typedef enum logic [1:0] {
    PWR_OFF   = 2'd0,
    PWR_LIVE  = 2'd1,
    PWR_GRACE = 2'd2,
    PWR_HOLD  = 2'd3
  } pwr_state_t;

  // Discharge unit states
  typedef enum logic [1:0] {
    CDU_IDLE   = 2'd0,
    CDU_CHARGE = 2'd1,
    CDU_ARMED  = 2'd2,
    CDU_MOVING = 2'd3
  } cdu_state_t;

endpackage

// File: rtl/trkpwr_mstick.sv
module trkpwr_mstick #(
  parameter int CYC_PER_MS = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_MS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/trkpwr_grace.sv
module trkpwr_grace #(
  parameter int GRACE_MS = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expired
);
  localparam int MW = $clog2(GRACE_MS + 1);
  localparam logic [MW-1:0] LAST = MW'(GRACE_MS - 1);

  logic [MW-1:0] ms_q, ms_d;

  // Fires in the final cycle of the window so the owner leaves on time (R5)
  assign expired = run && tick && (ms_q == LAST);

  always_comb begin
    ms_d = ms_q;
    if (!run)      ms_d = '0;
    else if (tick) ms_d = ms_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ms_q <= '0;
    else        ms_q <= ms_d;
  end
endmodule

// File: rtl/trkpwr_cdu.sv
module trkpwr_cdu
  import trkpwr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ready,
  input  logic point_req,
  input  logic point_done,
  output logic fire,
  output logic rpt_charged,
  output logic rpt_pointed,
  output logic rpt_err
);
  cdu_state_t st_q, st_d;
  logic fire_d, chg_d, pnt_d, err_d;
  logic accept;

  assign accept = enable && (st_q == CDU_ARMED) && point_req;

  always_comb begin
    st_d   = st_q;
    fire_d = 1'b0;
    chg_d  = 1'b0;
    pnt_d  = 1'b0;
    err_d  = point_req && !accept;          // R12
    if (!enable) begin
      st_d = CDU_IDLE;
    end else begin
      unique case (st_q)
        CDU_IDLE:   st_d = CDU_CHARGE;
        CDU_CHARGE: if (ready) begin        // R9
                      st_d  = CDU_ARMED;
                      chg_d = 1'b1;
                    end
        CDU_ARMED:  if (accept) begin       // R10
                      st_d   = CDU_MOVING;
                      fire_d = 1'b1;
                    end
        CDU_MOVING: if (point_done) begin   // R11
                      st_d  = CDU_CHARGE;
                      pnt_d = 1'b1;
                    end
        default:    st_d = CDU_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= CDU_IDLE;
      fire        <= 1'b0;
      rpt_charged <= 1'b0;
      rpt_pointed <= 1'b0;
      rpt_err     <= 1'b0;
    end else begin
      st_q        <= st_d;
      fire        <= fire_d;
      rpt_charged <= chg_d;
      rpt_pointed <= pnt_d;
      rpt_err     <= err_d;
    end
  end
endmodule

// File: rtl/trkpwr_sup.sv
module trkpwr_sup
  import trkpwr_pkg::*;
#(
  parameter int CYC_PER_MS = 50000,
  parameter int GRACE_MS   = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_on,
  input  logic cmd_off,
  input  logic cmd_point,
  input  logic short_det,
  input  logic cdu_ready,
  input  logic point_done,
  output logic trk_en,
  output logic cdu_en,
  output logic fire,
  output logic rpt_fault,
  output logic rpt_fixed,
  output logic rpt_charged,
  output logic rpt_pointed,
  output logic rpt_err
);
  pwr_state_t pwr_q, pwr_d;
  logic fault_d, fixed_d;
  logic grace_run, ms_tick, grace_done;

  assign trk_en    = (pwr_q == PWR_LIVE);
  assign cdu_en    = (pwr_q == PWR_LIVE) || (pwr_q == PWR_GRACE);
  assign grace_run = (pwr_q == PWR_GRACE);

  trkpwr_mstick #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (grace_run),
    .tick (ms_tick)
  );

  trkpwr_grace #(.GRACE_MS(GRACE_MS)) u_grace (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (grace_run),
    .tick   (ms_tick),
    .expired(grace_done)
  );

  trkpwr_cdu u_cdu (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (cdu_en),
    .ready      (cdu_ready),
    .point_req  (cmd_point),
    .point_done (point_done),
    .fire       (fire),
    .rpt_charged(rpt_charged),
    .rpt_pointed(rpt_pointed),
    .rpt_err    (rpt_err)
  );

  always_comb begin
    pwr_d   = pwr_q;
    fault_d = 1'b0;
    fixed_d = 1'b0;
    unique case (pwr_q)
      PWR_OFF:   if (cmd_on) pwr_d = PWR_LIVE;              // R2, R13
      PWR_LIVE:  if (short_det) begin                       // R4
                   pwr_d   = PWR_GRACE;
                   fault_d = 1'b1;
                 end else if (cmd_off) begin                // R3
                   pwr_d = PWR_OFF;
                 end
      PWR_GRACE: if (!short_det) begin                      // R8
                   pwr_d   = PWR_OFF;
                   fixed_d = 1'b1;
                 end else if (grace_done) begin             // R5, R6
                   pwr_d = PWR_HOLD;
                 end
      PWR_HOLD:  if (!short_det) begin                      // R8
                   pwr_d   = PWR_OFF;
                   fixed_d = 1'b1;
                 end else if (cmd_off) begin                // R7
                   pwr_d = PWR_OFF;
                 end
      default:   pwr_d = PWR_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q     <= PWR_OFF;
      rpt_fault <= 1'b0;
      rpt_fixed <= 1'b0;
    end else begin
      pwr_q     <= pwr_d;
      rpt_fault <= fault_d;
      rpt_fixed <= fixed_d;
    end
  end
endmodule

// File: rtl/trkpwr_chk.sv
module trkpwr_chk #(
  parameter int CYC_PER_MS = 50000,
  parameter int GRACE_MS   = 500
) (
  input logic clk,
  input logic rst_n,
  input logic trk_en,
  input logic cdu_en,
  input logic fire,
  input logic rpt_fault,
  input logic rpt_fixed,
  input logic rpt_charged,
  input logic rpt_pointed,
  input logic rpt_err
);
  localparam int LIM = CYC_PER_MS * GRACE_MS;
  localparam int GW  = $clog2(LIM + 2);

  logic [GW-1:0] win_q;

  // Counts cycles spent with track dead but unit armed (R5 window)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   win_q <= '0;
    else if (!(cdu_en && !trk_en))                win_q <= '0;
    else if (win_q != GW'(LIM + 1))               win_q <= win_q + 1'b1;
  end

  a_r5_grace_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (cdu_en && !trk_en) |-> (win_q < GW'(LIM)));

  a_r4_fault_cuts_track: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_fault |-> (!trk_en && cdu_en));

  a_r13_fault_needs_live: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_fault |-> $past(trk_en));

  a_r3_track_needs_cdu: assert property (@(posedge clk) disable iff (!rst_n)
    trk_en |-> cdu_en);

  a_r8_fixed_is_off: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_fixed |-> (!trk_en && !cdu_en));

  a_r8_fixed_single: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_fixed |=> !rpt_fixed);

  a_r10_fire_single: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);

  a_r10_fire_needs_cdu: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(cdu_en));

  a_r12_err_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_err |-> !fire);

  a_r9_charged_needs_cdu: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_charged |-> $past(cdu_en));

  a_r11_pointed_needs_cdu: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_pointed |-> $past(cdu_en));

endmodule

bind trkpwr_sup trkpwr_chk #(.CYC_PER_MS(CYC_PER_MS), .GRACE_MS(GRACE_MS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trk_en     (trk_en),
  .cdu_en     (cdu_en),
  .fire       (fire),
  .rpt_fault  (rpt_fault),
  .rpt_fixed  (rpt_fixed),
  .rpt_charged(rpt_charged),
  .rpt_pointed(rpt_pointed),
  .rpt_err    (rpt_err)
);

// File: tb/sim_trkpwr_sup.sv
module sim_trkpwr_sup;
  localparam int CPM = 4;
  localparam int GMS = 5;
  localparam int WIN = CPM * GMS;
  localparam int NV  = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_on, cmd_off, cmd_point, short_det, cdu_ready, point_done;
  logic trk_en, cdu_en, fire, rpt_fault, rpt_fixed, rpt_charged, rpt_pointed, rpt_err;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  trkpwr_sup #(.CYC_PER_MS(CPM), .GRACE_MS(GMS)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .cmd_off(cmd_off),
    .cmd_point(cmd_point), .short_det(short_det), .cdu_ready(cdu_ready),
    .point_done(point_done), .trk_en(trk_en), .cdu_en(cdu_en), .fire(fire),
    .rpt_fault(rpt_fault), .rpt_fixed(rpt_fixed), .rpt_charged(rpt_charged),
    .rpt_pointed(rpt_pointed), .rpt_err(rpt_err)
  );

  // inputs {on,off,point,short,ready,done} ; expected {trk,cdu,fire,fault,fixed,charged,pointed,err}
  localparam logic [13:0] VEC [0:NV-1] = '{
    {6'b000000, 8'b00000000},  // R1 idle after reset
    {6'b000100, 8'b00000000},  // R13 short while off
    {6'b001000, 8'b00000001},  // R12 point while disabled
    {6'b100000, 8'b11000000},  // R2 power on
    {6'b000000, 8'b11000000},  // R9 charging, not ready
    {6'b001000, 8'b11000001},  // R12 point while charging
    {6'b000010, 8'b11000100},  // R9 charged
    {6'b000010, 8'b11000000},  // R9 no repeat
    {6'b001010, 8'b11100000},  // R10 fire
    {6'b000000, 8'b11000000},  // R10 single pulse
    {6'b001000, 8'b11000001},  // R12 point while moving
    {6'b000001, 8'b11000010},  // R11 pointed
    {6'b000010, 8'b11000100},  // R11 recharged
    {6'b010000, 8'b00000000},  // R3 power off
    {6'b100000, 8'b11000000},  // R2 power on again
    {6'b000100, 8'b01010000},  // R4 fault
    {6'b010100, 8'b01000000},  // R6 off ignored in window
    {6'b100100, 8'b01000000},  // R8 on ignored in fault
    {6'b000000, 8'b00001000},  // R8 fixed
    {6'b000000, 8'b00000000}   // R8 stays off
  };
  localparam int VREQ [0:NV-1] = '{1,13,12,2,9,12,9,9,10,10,12,11,11,3,2,4,6,8,8,8};

  function automatic logic [7:0] outs();
    return {trk_en, cdu_en, fire, rpt_fault, rpt_fixed, rpt_charged, rpt_pointed, rpt_err};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [5:0] v);
    {cmd_on, cmd_off, cmd_point, short_det, cdu_ready, point_done} = v;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int w = 0; w < 5000; w++) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cnt;
    rst_n = 1'b0;
    drive(6'b0);
    repeat (3) @(negedge clk);
    chk("R1 in reset", 32'(outs()), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][13:8]);
      step();
      chk($sformatf("R%0d vector %0d", VREQ[i], i), 32'(outs()), 32'(VEC[i][7:0]));
    end

    // R5: exact window length, then R7: forced off without recovery report
    drive(6'b100000); step();
    chk("R2 on before window", 32'(trk_en), 32'h1);
    drive(6'b000100); step();
    chk("R4 fault strobe", 32'(rpt_fault), 32'h1);
    cnt = 0;
    while (cdu_en === 1'b1 && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    chk("R5 window cycles", 32'(cnt), 32'(WIN));
    chk("R5 track off", 32'(trk_en), 32'h0);
    drive(6'b010100); step();
    chk("R7 forced off", 32'(outs()), 32'h0);
    drive(6'b000000); step();
    chk("R7 no recovery report", 32'(rpt_fixed), 32'h0);
    drive(6'b100000); step();
    chk("R7 on accepted after forced off", 32'(trk_en), 32'h1);

    // R8: recovery after the window, on ignored while held
    drive(6'b000100); step();
    drive(6'b000100);
    repeat (WIN + 5) @(negedge clk);
    chk("R8 held unit off", 32'(cdu_en), 32'h0);
    drive(6'b100100); step();
    chk("R8 on ignored in hold", 32'(outs()), 32'h0);
    drive(6'b000000); step();
    chk("R8 recovery after window", 32'(outs()), 32'h08);
    step();
    chk("R8 recovery once", 32'(rpt_fixed), 32'h0);

    // R1: asynchronous reset while live
    drive(6'b100000); step();
    drive(6'b000000);
    chk("R2 live before reset", 32'(trk_en), 32'h1);
    #3 rst_n = 1'b0;
    #1 chk("R1 async reset", 32'(outs()), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R1 first cycle after reset", 32'(outs()), 32'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule